// File: doc/BRIEF.md
# In-Order Memory Micro-Op Dispatch Queue

This block is the single shared holding queue for all memory micro-ops of a core: scalar and vector loads and stores all wait in the same twelve slots. Allocation writes up to two micro-ops per cycle into the queue, in program order. Each micro-op carries one source operand tag. The entry becomes dispatchable once that operand is marked ready, either at allocation or later through a wakeup broadcast that carries the producer tag.

Entries leave for two memory pipes strictly in program order. If the oldest waiting entry is not ready, nothing dispatches that cycle. A second, younger entry goes out in the same cycle only as the pairing partner of the oldest one, and only when the two operation kinds may share a cycle.

Each dispatched entry is named by its slot id. The memory pipes report completion with that id, in any order. A slot returns to the free pool once it and every older entry have completed. The allocation side uses a valid/ready handshake: `alloc_ready` is a combinational function of the current occupancy and of how many lanes request a slot. A lane writes only in a cycle where `alloc_ready` is high. The dispatch pipes have no back-pressure; a raised `disp_valid` bit is always taken. Wakeup and completion are plain strobes.

Top module: `memq_dispatch`

## Requirements
- R1: After reset the queue is empty: `disp_valid` is 0, and `alloc_ready` is 1 for a two-lane request.
- R2: The queue holds 12 entries. `alloc_ready` is 1 exactly when the free slots are at least the number of raised `alloc_valid` lanes. With no lane raised it is 1. A request for two slots is refused when one slot is free, while a request for one slot is accepted.
- R3: Dispatch follows allocation order. While the oldest undispatched entry waits on its operand, no entry dispatches, even when a younger one is ready.
- R4: At most two entries dispatch per cycle. Port 1 is used only together with port 0, and it carries the entry directly after the one on port 0.
- R5: Two entries may pair when they are a load and a store in either order (any scalar/vector mix), or two loads of which at least one is a vector load (`is_vec`=1).
- R6: Two scalar loads (`is_store`=0, `is_vec`=0) never pair. The younger one goes out alone in the next cycle.
- R7: Two stores (`is_store`=1) never pair. The younger one goes out in the next cycle.
- R8: A wakeup whose tag equals an entry's source tag makes that entry dispatchable from the next cycle. A wakeup with a different tag has no effect.
- R9: Completions may arrive in any order. A completed slot is freed only after every older entry has completed. Up to two slots are freed per cycle, in age order.
- R10: Slot ids are handed out in order, starting at 0 after reset, incrementing per allocated entry, and wrapping from 11 to 0. Lane 0 is older than lane 1. The dispatch ids follow the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 2 | Allocation request per lane; lane 0 is older |
| alloc_ready | output | 2 → 1 | Queue can take all raised lanes this cycle |
| alloc_is_store | input | 2 | Per lane: 1 = store, 0 = load |
| alloc_is_vec | input | 2 | Per lane: 1 = vector, 0 = scalar |
| alloc_src_tag | input | 2×6 | Per lane source operand tag |
| alloc_src_rdy | input | 2 | Per lane: operand already available |
| wake_valid | input | 1 | Wakeup broadcast strobe |
| wake_tag | input | 6 | Tag of the operand that became ready |
| disp_valid | output | 2 | Dispatch on port 0 / port 1 |
| disp_is_store | output | 2 | Kind of the dispatched entry: store |
| disp_is_vec | output | 2 | Kind of the dispatched entry: vector |
| disp_id | output | 2×4 | Slot id of the dispatched entry |
| cmpl_valid | input | 2 | Completion strobe per pipe |
| cmpl_id | input | 2×4 | Slot id being completed |

## Verification
Dispatch is decoded from registered entry state. An entry written at an edge with its operand ready appears on the dispatch ports in the very next cycle, and a matching wakeup registered at an edge makes its entry eligible in the cycle after that edge. A completion sets the slot's done flag at one edge, and the space becomes visible on `alloc_ready` after the following edge. `alloc_ready` itself answers within the same cycle as the request. The bench changes inputs on the falling edge and reads outputs one nanosecond later. Each check therefore sees the state left by the previous rising edge combined with the inputs of the current cycle, counted from the edges listed above.

// File: rtl/memq_pkg.sv
package memq_pkg;

  // Operation kind of one queued memory micro-op
  typedef struct packed {
    logic is_store;
    logic is_vec;
  } uop_kind_t;

endpackage

// File: rtl/memq_pair_check.sv
// Decides whether the oldest ready entry may share a dispatch cycle with
// the entry right behind it.
module memq_pair_check
  import memq_pkg::*;
(
  input  uop_kind_t older,
  input  uop_kind_t younger,
  output logic      pair_ok
);

  logic mixed_dir;
  logic load_pair_has_vec;

  always_comb begin
    // read plus write in any order and any width: R5
    mixed_dir         = older.is_store ^ younger.is_store;
    // two reads only when not both scalar (R6); two writes never (R7)
    load_pair_has_vec = !older.is_store && !younger.is_store &&
                        (older.is_vec || younger.is_vec);
    pair_ok           = mixed_dir || load_pair_has_vec;
  end

endmodule

// File: rtl/memq_entry_file.sv
// Per-slot state of the queue: kind, operand tag and lifecycle flags.
module memq_entry_file
  import memq_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int TAG_W = 6,
  parameter int ID_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 wr_en,
  input  logic [1:0][ID_W-1:0]       wr_idx,
  input  uop_kind_t [1:0]            wr_kind,
  input  logic [1:0][TAG_W-1:0]      wr_tag,
  input  logic [1:0]                 wr_rdy,
  input  logic                       wake_valid,
  input  logic [TAG_W-1:0]           wake_tag,
  input  logic [1:0]                 iss_en,
  input  logic [1:0][ID_W-1:0]       iss_idx,
  input  logic [1:0]                 cmp_en,
  input  logic [1:0][ID_W-1:0]       cmp_idx,
  input  logic [1:0]                 ret_en,
  input  logic [1:0][ID_W-1:0]       ret_idx,
  output logic [DEPTH-1:0]           rdy_o,
  output logic [DEPTH-1:0]           done_o,
  output uop_kind_t [DEPTH-1:0]      kind_o
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    localparam logic [ID_W-1:0] SLOT = ID_W'(e);

    logic            busy_q, rdy_q, iss_q, done_q;
    uop_kind_t       kind_q;
    logic [TAG_W-1:0] tag_q;
    logic            hit_w0, hit_w1, hit_ret, hit_iss, hit_cmp;

    always_comb begin
      hit_w0  = wr_en[0]  && (wr_idx[0]  == SLOT);
      hit_w1  = wr_en[1]  && (wr_idx[1]  == SLOT);
      hit_ret = (ret_en[0] && (ret_idx[0] == SLOT)) ||
                (ret_en[1] && (ret_idx[1] == SLOT));
      hit_iss = (iss_en[0] && (iss_idx[0] == SLOT)) ||
                (iss_en[1] && (iss_idx[1] == SLOT));
      hit_cmp = (cmp_en[0] && (cmp_idx[0] == SLOT)) ||
                (cmp_en[1] && (cmp_idx[1] == SLOT));
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        rdy_q  <= 1'b0;
        iss_q  <= 1'b0;
        done_q <= 1'b0;
        kind_q <= '0;
        tag_q  <= '0;
      end else if (hit_w0 || hit_w1) begin
        busy_q <= 1'b1;
        rdy_q  <= hit_w0 ? wr_rdy[0]  : wr_rdy[1];
        kind_q <= hit_w0 ? wr_kind[0] : wr_kind[1];
        tag_q  <= hit_w0 ? wr_tag[0]  : wr_tag[1];
        iss_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (hit_ret) begin
        busy_q <= 1'b0;
        rdy_q  <= 1'b0;
        iss_q  <= 1'b0;
        done_q <= 1'b0;
      end else begin
        if (busy_q && wake_valid && (tag_q == wake_tag)) rdy_q <= 1'b1;
        if (hit_iss)           iss_q  <= 1'b1;
        if (hit_cmp && iss_q)  done_q <= 1'b1;
      end
    end

    assign rdy_o[e]  = busy_q && rdy_q;
    assign done_o[e] = done_q;
    assign kind_o[e] = kind_q;
  end

endmodule

// File: rtl/memq_dispatch.sv
// Twelve-slot shared memory micro-op queue with in-order dual dispatch.
module memq_dispatch
  import memq_pkg::*;
#(
  parameter  int DEPTH = 12,
  parameter  int TAG_W = 6,
  localparam int ID_W  = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            alloc_valid,
  output logic                  alloc_ready,
  input  logic [1:0]            alloc_is_store,
  input  logic [1:0]            alloc_is_vec,
  input  logic [1:0][TAG_W-1:0] alloc_src_tag,
  input  logic [1:0]            alloc_src_rdy,
  input  logic                  wake_valid,
  input  logic [TAG_W-1:0]      wake_tag,
  output logic [1:0]            disp_valid,
  output logic [1:0]            disp_is_store,
  output logic [1:0]            disp_is_vec,
  output logic [1:0][ID_W-1:0]  disp_id,
  input  logic [1:0]            cmpl_valid,
  input  logic [1:0][ID_W-1:0]  cmpl_id
);

  function automatic logic [ID_W-1:0] step_id(input logic [ID_W-1:0] p);
    return (p == ID_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // oldest live slot, next slot to dispatch, next slot to allocate
  logic [ID_W-1:0]  head_q, nxt_q, tail_q;
  logic [CNT_W-1:0] occ_q, pend_q;

  logic [CNT_W-1:0] need, free_cnt, n_alloc, n_disp, n_ret, n_issued;
  logic [1:0]             wr_en, wr_rdy, ret_en;
  logic [1:0][ID_W-1:0]   wr_idx, ret_idx;
  uop_kind_t [1:0]        wr_kind;
  logic [DEPTH-1:0]       rdy_v, done_v;
  uop_kind_t [DEPTH-1:0]  kind_v;
  logic [ID_W-1:0]        nxt1, head1;
  logic                   pair_ok, d0, d1, r0, r1;

  // ---------------- allocation side (R2, R10)
  always_comb begin
    need        = CNT_W'(alloc_valid[0]) + CNT_W'(alloc_valid[1]);
    free_cnt    = CNT_W'(DEPTH) - occ_q;
    alloc_ready = (free_cnt >= need);
    n_alloc     = alloc_ready ? need : '0;
    wr_en       = alloc_ready ? alloc_valid : 2'b00;
    wr_idx[0]   = tail_q;
    wr_idx[1]   = alloc_valid[0] ? step_id(tail_q) : tail_q;
    for (int k = 0; k < 2; k++) begin
      wr_kind[k].is_store = alloc_is_store[k];
      wr_kind[k].is_vec   = alloc_is_vec[k];
      wr_rdy[k] = alloc_src_rdy[k] ||
                  (wake_valid && (alloc_src_tag[k] == wake_tag));
    end
  end

  // ---------------- in-order dispatch (R3 to R7)
  assign nxt1 = step_id(nxt_q);

  memq_pair_check u_pair (
    .older   (kind_v[nxt_q]),
    .younger (kind_v[nxt1]),
    .pair_ok (pair_ok)
  );

  always_comb begin
    d0     = (pend_q != '0) && rdy_v[nxt_q];
    d1     = d0 && (pend_q >= CNT_W'(2)) && rdy_v[nxt1] && pair_ok;
    n_disp = CNT_W'(d0) + CNT_W'(d1);
    disp_valid       = {d1, d0};
    disp_id[0]       = nxt_q;
    disp_id[1]       = nxt1;
    disp_is_store[0] = kind_v[nxt_q].is_store;
    disp_is_store[1] = kind_v[nxt1].is_store;
    disp_is_vec[0]   = kind_v[nxt_q].is_vec;
    disp_is_vec[1]   = kind_v[nxt1].is_vec;
  end

  // ---------------- age-ordered release (R9)
  assign head1 = step_id(head_q);

  always_comb begin
    n_issued   = occ_q - pend_q;
    r0         = (n_issued != '0) && done_v[head_q];
    r1         = r0 && (n_issued >= CNT_W'(2)) && done_v[head1];
    n_ret      = CNT_W'(r0) + CNT_W'(r1);
    ret_en     = {r1, r0};
    ret_idx[0] = head_q;
    ret_idx[1] = head1;
  end

  memq_entry_file #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W),
    .ID_W  (ID_W)
  ) u_entries (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_kind    (wr_kind),
    .wr_tag     (alloc_src_tag),
    .wr_rdy     (wr_rdy),
    .wake_valid (wake_valid),
    .wake_tag   (wake_tag),
    .iss_en     ({d1, d0}),
    .iss_idx    ({nxt1, nxt_q}),
    .cmp_en     (cmpl_valid),
    .cmp_idx    (cmpl_id),
    .ret_en     (ret_en),
    .ret_idx    (ret_idx),
    .rdy_o      (rdy_v),
    .done_o     (done_v),
    .kind_o     (kind_v)
  );

  // ---------------- pointer and count registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      nxt_q  <= '0;
      tail_q <= '0;
      occ_q  <= '0;
      pend_q <= '0;
    end else begin
      if (n_alloc == CNT_W'(2))      tail_q <= step_id(step_id(tail_q));
      else if (n_alloc == CNT_W'(1)) tail_q <= step_id(tail_q);
      if (d1)      nxt_q <= step_id(nxt1);
      else if (d0) nxt_q <= nxt1;
      if (r1)      head_q <= step_id(head1);
      else if (r0) head_q <= head1;
      occ_q  <= occ_q + n_alloc - n_ret;
      pend_q <= pend_q + n_alloc - n_disp;
    end
  end

endmodule

// File: rtl/memq_dispatch_chk.sv
module memq_dispatch_chk #(
  parameter  int DEPTH = 12,
  localparam int ID_W  = $clog2(DEPTH)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           alloc_valid,
  input logic                 alloc_ready,
  input logic [1:0]           disp_valid,
  input logic [1:0]           disp_is_store,
  input logic [1:0]           disp_is_vec,
  input logic [1:0][ID_W-1:0] disp_id
);

  function automatic logic [ID_W-1:0] nxt_id(input logic [ID_W-1:0] p);
    return (p == ID_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // independent model of the next id due on port 0
  logic [ID_W-1:0] exp_id_q;
  always_ff @(posedge clk) begin
    if (!rst_n)             exp_id_q <= '0;
    else if (disp_valid[1]) exp_id_q <= nxt_id(nxt_id(exp_id_q));
    else if (disp_valid[0]) exp_id_q <= nxt_id(exp_id_q);
  end

  a_r2_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid == 2'b00) |-> alloc_ready);

  a_r4_port1_needs_port0: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid[1] |-> disp_valid[0]);

  a_r4_port1_follows: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid[1] |-> (disp_id[1] == nxt_id(disp_id[0])));

  a_r6_no_scalar_load_pair: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid[1] |-> !(disp_is_store == 2'b00 && disp_is_vec == 2'b00));

  a_r7_no_store_pair: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid[1] |-> (disp_is_store != 2'b11));

  a_r10_id_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid[0] |-> (disp_id[0] == exp_id_q));

endmodule

bind memq_dispatch memq_dispatch_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/memq_dispatch_tb.sv
module memq_dispatch_tb_top;

  localparam int DEPTH = 12;
  localparam int TAG_W = 6;
  localparam int ID_W  = 4;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [1:0]            alloc_valid = '0;
  logic                  alloc_ready;
  logic [1:0]            alloc_is_store = '0;
  logic [1:0]            alloc_is_vec = '0;
  logic [1:0][TAG_W-1:0] alloc_src_tag = '0;
  logic [1:0]            alloc_src_rdy = '0;
  logic                  wake_valid = 1'b0;
  logic [TAG_W-1:0]      wake_tag = '0;
  logic [1:0]            disp_valid;
  logic [1:0]            disp_is_store;
  logic [1:0]            disp_is_vec;
  logic [1:0][ID_W-1:0]  disp_id;
  logic [1:0]            cmpl_valid = '0;
  logic [1:0][ID_W-1:0]  cmpl_id = '0;

  int n_run = 0;
  int n_fail = 0;
  int nid = 0;

  always #2 clk = ~clk;

  memq_dispatch #(.DEPTH(DEPTH), .TAG_W(TAG_W)) dut_i (.*);

  // {older is_store, older is_vec, younger is_store, younger is_vec, pairs}
  localparam logic [4:0] PAIR_VEC [8] = '{
    5'b00_00_0,  // two scalar loads: R6
    5'b01_01_1,  // two vector loads: R5
    5'b00_01_1,  // scalar + vector load: R5
    5'b10_00_1,  // store then load: R5
    5'b01_11_1,  // vector load then vector store: R5
    5'b10_10_0,  // two stores: R7
    5'b11_10_0,  // two stores mixed width: R7
    5'b00_11_1   // scalar load then vector store: R5
  };

  function automatic int wrap(input int v);
    return v % DEPTH;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    alloc_valid = 2'b11;
    #1;
    check(disp_valid == 2'b00, "R1 idle dispatch", disp_valid, 0);
    check(alloc_ready == 1'b1, "R1 ready after reset", alloc_ready, 1);
    alloc_valid = 2'b00;

    // table of kind pairs: R5 R6 R7 R4 R10
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      alloc_valid    = 2'b11;
      alloc_is_store = {PAIR_VEC[i][2], PAIR_VEC[i][4]};
      alloc_is_vec   = {PAIR_VEC[i][1], PAIR_VEC[i][3]};
      alloc_src_rdy  = 2'b11;
      #1;
      check(alloc_ready == 1'b1, "R2 space for pair", alloc_ready, 1);
      @(negedge clk);
      alloc_valid = 2'b00;
      #1;
      check(disp_valid[0] && disp_id[0] == ID_W'(nid), "R10 oldest id",
            disp_id[0], nid);
      check(disp_valid[1] == PAIR_VEC[i][0],
            PAIR_VEC[i][0] ? "R5 pair allowed" :
            (PAIR_VEC[i][4] ? "R7 store pair split" : "R6 scalar load split"),
            disp_valid[1], PAIR_VEC[i][0]);
      if (!PAIR_VEC[i][0]) begin
        @(negedge clk);
        #1;
        check(disp_valid == 2'b01 && disp_id[0] == ID_W'(wrap(nid + 1)),
              "R4 younger next cycle", disp_id[0], wrap(nid + 1));
      end
      @(negedge clk);
      cmpl_valid = 2'b11;
      cmpl_id[0] = ID_W'(wrap(nid + 1));
      cmpl_id[1] = ID_W'(nid);
      @(negedge clk);
      cmpl_valid = 2'b00;
      repeat (2) @(negedge clk);
      nid = wrap(nid + 2);
    end

    // R3 and R8: blocked oldest, then wakeup
    @(negedge clk);
    alloc_valid      = 2'b11;
    alloc_is_store   = 2'b00;
    alloc_is_vec     = 2'b10;
    alloc_src_rdy    = 2'b10;
    alloc_src_tag[0] = 6'd5;
    alloc_src_tag[1] = 6'd0;
    @(negedge clk);
    alloc_valid = 2'b00;
    #1;
    check(disp_valid == 2'b00, "R3 younger held behind oldest", disp_valid, 0);
    wake_valid = 1'b1;
    wake_tag   = 6'd7;
    @(negedge clk);
    wake_valid = 1'b0;
    #1;
    check(disp_valid == 2'b00, "R8 unrelated tag ignored", disp_valid, 0);
    wake_valid = 1'b1;
    wake_tag   = 6'd5;
    @(negedge clk);
    wake_valid = 1'b0;
    #1;
    check(disp_valid == 2'b11, "R8 wakeup releases pair", disp_valid, 3);
    check(disp_id[0] == ID_W'(nid) && disp_id[1] == ID_W'(wrap(nid + 1)),
          "R3 order kept", disp_id[0], nid);
    @(negedge clk);
    cmpl_valid = 2'b01;
    cmpl_id[0] = ID_W'(wrap(nid + 1));
    @(negedge clk);
    cmpl_id[0] = ID_W'(nid);
    @(negedge clk);
    cmpl_valid = 2'b00;
    repeat (3) @(negedge clk);
    nid = wrap(nid + 2);

    // R2 capacity, then R9 release order
    alloc_is_store   = 2'b00;
    alloc_is_vec     = 2'b11;
    alloc_src_rdy    = 2'b00;
    alloc_src_tag[0] = 6'd9;
    alloc_src_tag[1] = 6'd9;
    for (int k = 0; k < 5; k++) begin
      alloc_valid = 2'b11;
      #1;
      check(alloc_ready == 1'b1, "R2 filling", alloc_ready, 1);
      @(negedge clk);
    end
    alloc_valid = 2'b01;
    #1;
    check(alloc_ready == 1'b1, "R2 eleventh slot", alloc_ready, 1);
    @(negedge clk);
    alloc_valid = 2'b11;
    #1;
    check(alloc_ready == 1'b0, "R2 pair refused with one free", alloc_ready, 0);
    alloc_valid = 2'b01;
    #1;
    check(alloc_ready == 1'b1, "R2 single fits last slot", alloc_ready, 1);
    @(negedge clk);
    #1;
    check(alloc_ready == 1'b0, "R2 full queue", alloc_ready, 0);
    alloc_valid = 2'b00;
    wake_valid  = 1'b1;
    wake_tag    = 6'd9;
    @(negedge clk);
    wake_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      #1;
      check(disp_valid == 2'b11 && disp_id[0] == ID_W'(wrap(nid + 2 * k)),
            "R4 full-rate drain", disp_id[0], wrap(nid + 2 * k));
      @(negedge clk);
    end
    // complete all but the oldest, youngest first
    for (int k = 11; k >= 1; k -= 2) begin
      cmpl_valid = (k == 1) ? 2'b01 : 2'b11;
      cmpl_id[0] = ID_W'(wrap(nid + k));
      cmpl_id[1] = ID_W'(wrap(nid + k - 1));
      @(negedge clk);
    end
    cmpl_valid = 2'b00;
    repeat (2) @(negedge clk);
    alloc_valid = 2'b01;
    #1;
    check(alloc_ready == 1'b0, "R9 oldest incomplete holds space", alloc_ready, 0);
    check(disp_valid == 2'b00, "R9 nothing left to send", disp_valid, 0);
    alloc_valid = 2'b00;
    cmpl_valid  = 2'b01;
    cmpl_id[0]  = ID_W'(nid);
    @(negedge clk);
    cmpl_valid  = 2'b00;
    alloc_valid = 2'b01;
    #1;
    check(alloc_ready == 1'b0, "R9 release lags completion", alloc_ready, 0);
    alloc_valid = 2'b00;
    @(negedge clk);
    alloc_valid = 2'b11;
    #1;
    check(alloc_ready == 1'b1, "R9 two slots freed in order", alloc_ready, 1);
    alloc_valid = 2'b00;
    repeat (2) @(negedge clk);

    finish_run();
  end

endmodule